// File: doc/BRIEF.md
# Hierarchical Masked Interrupt Aggregator

This block gathers interrupt events into one output line through two levels of pending and mask registers. A USB-core group and a DMA-completion group each keep a 32-bit pending word, fed both by hardware event inputs and by software writes to set and clear addresses, plus a mask word in which a 1 blocks a bit. Each group folds into summary bits of a 32-bit top-level pending word. The USB-core group folds separately: its lower half drives a transmit summary, its upper half a receive summary. The top level ANDs pending with the inverse of its own mask, ORs the result and drives one registered interrupt line. A configuration bit selects whether the line is high-active or low-active.

A power-up hold-off gate keeps the line at 0 after power is applied. A four-state machine tracks the power input: `PW_OFF_GATED` (off, gate closed), `PW_HOLD` (on, counting the hold-off), `PW_LIVE` (on, gate open) and `PW_OFF_LIVE` (off, gate still open). The transitions are:
- Reset enters `PW_OFF_GATED`.
- `PW_OFF_GATED` goes to `PW_HOLD` when power rises.
- `PW_HOLD` goes to `PW_LIVE` when the count reaches `HOLD_CYCLES`, or back to `PW_OFF_GATED` if power falls first.
- `PW_LIVE` goes to `PW_OFF_LIVE` when power falls.
- `PW_OFF_LIVE` goes to `PW_HOLD` when power rises again.

While the gate is closed the line is 0, whatever the polarity.

Top module: `intc_fold_ctrl`

## Requirements
- R1: After reset the top-level mask reads all ones; every pending word, the group masks and the configuration word read zero; `irq_out` is 0.
- R2: Word address map: top group 0..3, USB group 4..7, DMA group 8..11, configuration 12. Within a group the offsets are +0 pending, +1 set, +2 clear, +3 mask. A write to set ORs `wdata` into pending. A write to clear zeroes the bits written as 1. Writes to a pending address are ignored. When a bit is set and cleared in the same cycle, by software or by hardware event, the clear wins.
- R3: A mask bit of 1 stops its pending bit from reaching the summary or the line, while the pending bit itself is kept.
- R4: Top-level bit 9 is 1 when any unmasked USB pending bit in 15:0 is set.
- R5: Top-level bit 8 is 1 when any unmasked USB pending bit in 31:16 is set.
- R6: Top-level bit 24 is 1 when any unmasked DMA pending bit is set.
- R7: Top-level bits 8, 9 and 24 always follow the groups. Top-level set or clear writes do not change them.
- R8: When configuration bit 17 is 1, the line is the OR of top pending AND NOT top mask. When bit 17 is 0, the line is the inverse of that OR. In both cases the line is ANDed with the hold-off gate.
- R9: When `pwr_on` rises, the gate closes at once. It opens `HOLD_CYCLES` cycles later if power is still on. If power falls during the hold, the gate stays closed. A fall of power after the gate has opened leaves it open.
- R10: Reading a set or clear address returns that group's pending word. Unmapped addresses read zero, and writes to them have no effect.
- R11: `irq_out` is registered. It reflects a write, event or gate change one clock after the register it depends on updates.
- R12: Each bit of `usb_evt` or `dma_evt` held for one cycle sets the matching pending bit of its group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_on | input | 1 | Power-applied level |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Word address for read and write |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for `addr`, combinational |
| usb_evt | input | DW | USB-core hardware event bits |
| dma_evt | input | DW | DMA-completion hardware event bits |
| irq_out | output | 1 | Interrupt line |

## Verification
Pending words, masks and summary bits take a write or event at one clock edge, and the bench reads them back through `rdata` a nanosecond after that edge. The line is one register later, so every line check follows the write edge by exactly one further edge and samples at the falling edge. The hold-off checks count edges from the one that samples `pwr_on` high. The line must still be 0 after `HOLD_CYCLES`+1 edges and must be released after `HOLD_CYCLES`+2. A dedicated check confirms the line has not yet moved on the write edge itself.

// File: rtl/intc_pkg.sv
package intc_pkg;

    // Power hold-off states
    typedef enum logic [1:0] {
        PW_OFF_GATED = 2'd0,
        PW_HOLD      = 2'd1,
        PW_LIVE      = 2'd2,
        PW_OFF_LIVE  = 2'd3
    } pw_state_e;

    // Register kind inside a group, taken from the two low address bits
    typedef enum logic [1:0] {
        RK_PEND = 2'd0,
        RK_SET  = 2'd1,
        RK_CLR  = 2'd2,
        RK_MASK = 2'd3
    } reg_kind_e;

    localparam int unsigned NGRP      = 3;   // top, USB core, DMA
    localparam int unsigned GRP_TOP   = 0;
    localparam int unsigned GRP_USB   = 1;
    localparam int unsigned GRP_DMA   = 2;
    localparam int unsigned CFG_WORD  = NGRP * 4;

    localparam int unsigned BIT_USB_RX = 8;
    localparam int unsigned BIT_USB_TX = 9;
    localparam int unsigned BIT_DMA    = 24;
    localparam int unsigned BIT_POL    = 17;

endpackage

// File: rtl/intc_decode.sv
module intc_decode
    import intc_pkg::*;
#(
    parameter int unsigned AW = 6
) (
    input  logic [AW-1:0] addr,
    output logic          hit_grp,
    output logic [1:0]    grp,
    output reg_kind_e     kind,
    output logic          hit_cfg
);

    localparam logic [AW-1:0] GRP_END = AW'(NGRP * 4);
    localparam logic [AW-1:0] CFG_AD  = AW'(CFG_WORD);

    always_comb begin
        hit_grp = (addr < GRP_END);
        hit_cfg = (addr == CFG_AD);
        grp     = addr[3:2];
        kind    = reg_kind_e'(addr[1:0]);
    end

endmodule

// File: rtl/intc_group.sv
module intc_group #(
    parameter int unsigned     DW        = 32,
    parameter logic [DW-1:0]   MASK_RST  = '0,
    parameter logic [DW-1:0]   TIED_ZERO = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_set,
    input  logic          wr_clr,
    input  logic          wr_mask,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] hw_set,
    output logic [DW-1:0] pend,
    output logic [DW-1:0] mask
);

    logic [DW-1:0] set_vec;
    logic [DW-1:0] clr_vec;
    logic [DW-1:0] pend_d;

    always_comb begin
        set_vec = (wr_set ? wdata : '0) | hw_set;
        clr_vec = wr_clr ? wdata : '0;
        // clear takes precedence over any set arriving in the same cycle
        pend_d  = ((pend | set_vec) & ~clr_vec) & ~TIED_ZERO;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
            mask <= MASK_RST;
        end else begin
            pend <= pend_d;
            if (wr_mask) begin
                mask <= wdata;
            end
        end
    end

endmodule

// File: rtl/intc_holdoff.sv
module intc_holdoff
    import intc_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = 30_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_on,
    output logic gate
);

    localparam int unsigned   CW   = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

    pw_state_e     st_q;
    pw_state_e     st_d;
    logic [CW-1:0] cnt_q;

    // state register and hold counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= PW_OFF_GATED;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            if (st_q == PW_HOLD && st_d == PW_HOLD) begin
                cnt_q <= cnt_q + 1'b1;
            end else begin
                cnt_q <= '0;
            end
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PW_OFF_GATED: if (pwr_on) st_d = PW_HOLD;
            PW_HOLD: begin
                if (!pwr_on) begin
                    st_d = PW_OFF_GATED;
                end else if (cnt_q == LAST) begin
                    st_d = PW_LIVE;
                end
            end
            PW_LIVE:      if (!pwr_on) st_d = PW_OFF_LIVE;
            PW_OFF_LIVE:  if (pwr_on)  st_d = PW_HOLD;
            default:      st_d = PW_OFF_GATED;
        endcase
    end

    // outputs
    always_comb begin
        unique case (st_q)
            PW_LIVE, PW_OFF_LIVE: gate = 1'b1;
            default:              gate = 1'b0;
        endcase
    end

endmodule

// File: rtl/intc_line.sv
module intc_line #(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] pend,
    input  logic [DW-1:0] mask,
    input  logic          pol_high,
    input  logic          gate,
    output logic          any_act,
    output logic          irq_q
);

    always_comb begin
        any_act = |(pend & ~mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= gate & (pol_high ? any_act : ~any_act);
        end
    end

endmodule

// File: rtl/intc_fold_ctrl.sv
module intc_fold_ctrl
    import intc_pkg::*;
#(
    parameter int unsigned DW          = 32,
    parameter int unsigned AW          = 6,
    parameter int unsigned HOLD_CYCLES = 30_000_000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_on,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic [DW-1:0] usb_evt,
    input  logic [DW-1:0] dma_evt,
    output logic          irq_out
);

    localparam int unsigned   HALF     = DW / 2;
    localparam logic [DW-1:0] SUM_BITS = (DW'(1) << BIT_USB_RX)
                                       | (DW'(1) << BIT_USB_TX)
                                       | (DW'(1) << BIT_DMA);

    logic          hit_grp;
    logic          hit_cfg;
    logic [1:0]    grp;
    reg_kind_e     kind;

    logic [DW-1:0] grp_pend [NGRP];
    logic [DW-1:0] grp_mask [NGRP];
    logic [DW-1:0] hw_src   [NGRP];
    logic [NGRP-1:0] we_set;
    logic [NGRP-1:0] we_clr;
    logic [NGRP-1:0] we_mask;

    logic [DW-1:0] cfg_q;
    logic [DW-1:0] sum_vec;
    logic [DW-1:0] top_pend_eff;
    logic          gate;
    logic          any_act;

    intc_decode #(.AW(AW)) u_dec (
        .addr    (addr),
        .hit_grp (hit_grp),
        .grp     (grp),
        .kind    (kind),
        .hit_cfg (hit_cfg)
    );

    assign hw_src[GRP_TOP] = '0;
    assign hw_src[GRP_USB] = usb_evt;
    assign hw_src[GRP_DMA] = dma_evt;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam logic [DW-1:0] M_RST = (g == GRP_TOP) ? '1 : '0;
        localparam logic [DW-1:0] TIE0  = (g == GRP_TOP) ? SUM_BITS : '0;

        assign we_set[g]  = wr_en && hit_grp && (grp == 2'(g)) && (kind == RK_SET);
        assign we_clr[g]  = wr_en && hit_grp && (grp == 2'(g)) && (kind == RK_CLR);
        assign we_mask[g] = wr_en && hit_grp && (grp == 2'(g)) && (kind == RK_MASK);

        intc_group #(.DW(DW), .MASK_RST(M_RST), .TIED_ZERO(TIE0)) u_grp (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_set  (we_set[g]),
            .wr_clr  (we_clr[g]),
            .wr_mask (we_mask[g]),
            .wdata   (wdata),
            .hw_set  (hw_src[g]),
            .pend    (grp_pend[g]),
            .mask    (grp_mask[g])
        );
    end

    // configuration word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_en && hit_cfg) begin
            cfg_q <= wdata;
        end
    end

    // fold second-level groups into top-level summary bits
    always_comb begin
        sum_vec = '0;
        sum_vec[BIT_USB_TX] = |(grp_pend[GRP_USB][HALF-1:0]  & ~grp_mask[GRP_USB][HALF-1:0]);
        sum_vec[BIT_USB_RX] = |(grp_pend[GRP_USB][DW-1:HALF] & ~grp_mask[GRP_USB][DW-1:HALF]);
        sum_vec[BIT_DMA]    = |(grp_pend[GRP_DMA] & ~grp_mask[GRP_DMA]);
        top_pend_eff        = grp_pend[GRP_TOP] | sum_vec;
    end

    intc_holdoff #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .pwr_on (pwr_on),
        .gate   (gate)
    );

    intc_line #(.DW(DW)) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend     (top_pend_eff),
        .mask     (grp_mask[GRP_TOP]),
        .pol_high (cfg_q[BIT_POL]),
        .gate     (gate),
        .any_act  (any_act),
        .irq_q    (irq_out)
    );

    // read path: set and clear addresses mirror pending
    always_comb begin
        rdata = '0;
        if (hit_grp) begin
            if (kind == RK_MASK) begin
                rdata = grp_mask[grp];
            end else if (grp == 2'(GRP_TOP)) begin
                rdata = top_pend_eff;
            end else begin
                rdata = grp_pend[grp];
            end
        end else if (hit_cfg) begin
            rdata = cfg_q;
        end
    end

endmodule

// File: rtl/intc_fold_chk.sv
module intc_fold_chk
    import intc_pkg::*;
#(
    parameter int unsigned DW = 32,
    parameter int unsigned AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pwr_on,
    input logic          wr_en,
    input logic [AW-1:0] addr,
    input logic [DW-1:0] wdata,
    input logic [DW-1:0] usb_pend,
    input logic [DW-1:0] usb_mask,
    input logic [DW-1:0] dma_mask,
    input logic [DW-1:0] top_pend_eff,
    input logic          gate,
    input logic          pol,
    input logic          any_act,
    input logic          irq_out
);

    localparam int unsigned   HALF   = DW / 2;
    localparam logic [AW-1:0] A_USET = AW'(GRP_USB * 4 + 1);
    localparam logic [AW-1:0] A_UCLR = AW'(GRP_USB * 4 + 2);
    localparam logic [AW-1:0] A_DSET = AW'(GRP_DMA * 4 + 1);

    logic past_ok;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    p_clear_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && wr_en && addr == A_UCLR) |=> ((usb_pend & $past(wdata)) == '0));

    p_tx_fold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_USET && |(wdata[HALF-1:0] & ~usb_mask[HALF-1:0]))
        |=> top_pend_eff[BIT_USB_TX]);

    p_rx_fold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_USET && |(wdata[DW-1:HALF] & ~usb_mask[DW-1:HALF]))
        |=> top_pend_eff[BIT_USB_RX]);

    p_dma_fold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_DSET && |(wdata & ~dma_mask)) |=> top_pend_eff[BIT_DMA]);

    p_pol_high_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (gate && pol && !any_act) |=> !irq_out);

    p_pol_low_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (gate && !pol && !any_act) |=> irq_out);

    p_gate_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate) |=> !irq_out);

    p_rise_closes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $rose(pwr_on)) |=> !gate);

endmodule

bind intc_fold_ctrl intc_fold_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwr_on       (pwr_on),
    .wr_en        (wr_en),
    .addr         (addr),
    .wdata        (wdata),
    .usb_pend     (grp_pend[1]),
    .usb_mask     (grp_mask[1]),
    .dma_mask     (grp_mask[2]),
    .top_pend_eff (top_pend_eff),
    .gate         (gate),
    .pol          (cfg_q[17]),
    .any_act      (any_act),
    .irq_out      (irq_out)
);

// File: tb/intc_fold_ctrl_bench.sv
`timescale 1ns/1ps
module intc_fold_ctrl_bench;

    localparam int unsigned DW   = 32;
    localparam int unsigned AW   = 6;
    localparam int unsigned HOLD = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          pwr_on;
    logic          wr_en;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rdata;
    logic [DW-1:0] usb_evt;
    logic [DW-1:0] dma_evt;
    logic          irq_out;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    intc_fold_ctrl #(.DW(DW), .AW(AW), .HOLD_CYCLES(HOLD)) u_intc_fold_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .pwr_on  (pwr_on),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .usb_evt (usb_evt),
        .dma_evt (dma_evt),
        .irq_out (irq_out)
    );

    typedef struct packed {
        logic [5:0]  wa;
        logic [31:0] wd;
        logic [5:0]  ra;
        logic [31:0] rexp;
        logic        irq;
        logic [3:0]  req;
    } vec_t;

    // polarity high, top mask clear, gate open when the walk starts
    localparam vec_t VECS [19] = '{
        '{6'd5,  32'h0000_0001, 6'd0,  32'h0000_0200, 1'b1, 4'd4},  // R4 TX fold
        '{6'd6,  32'h0000_0001, 6'd0,  32'h0000_0000, 1'b0, 4'd2},  // R2 clear
        '{6'd5,  32'h0001_0000, 6'd0,  32'h0000_0100, 1'b1, 4'd5},  // R5 RX fold
        '{6'd7,  32'h0001_0000, 6'd0,  32'h0000_0000, 1'b0, 4'd3},  // R3 group mask
        '{6'd7,  32'h0000_0000, 6'd5,  32'h0001_0000, 1'b1, 4'd10}, // R10 set mirror
        '{6'd6,  32'hFFFF_FFFF, 6'd6,  32'h0000_0000, 1'b0, 4'd10}, // R10 clear mirror
        '{6'd9,  32'h0000_0008, 6'd0,  32'h0100_0000, 1'b1, 4'd6},  // R6 DMA fold
        '{6'd11, 32'h0000_0008, 6'd8,  32'h0000_0008, 1'b0, 4'd3},  // R3 kept pending
        '{6'd10, 32'h0000_0008, 6'd8,  32'h0000_0000, 1'b0, 4'd2},  // R2 DMA clear
        '{6'd11, 32'h0000_0000, 6'd11, 32'h0000_0000, 1'b0, 4'd3},  // R3 mask read
        '{6'd1,  32'h0000_0001, 6'd0,  32'h0000_0001, 1'b1, 4'd2},  // R2 top set
        '{6'd3,  32'h0000_0001, 6'd3,  32'h0000_0001, 1'b0, 4'd3},  // R3 top mask
        '{6'd1,  32'h0100_0300, 6'd0,  32'h0000_0001, 1'b0, 4'd7},  // R7 summary untouched
        '{6'd3,  32'h0000_0000, 6'd0,  32'h0000_0001, 1'b1, 4'd3},  // R3 unmask
        '{6'd12, 32'h0000_0000, 6'd12, 32'h0000_0000, 1'b0, 4'd8},  // R8 low-active, busy
        '{6'd2,  32'h0000_0001, 6'd0,  32'h0000_0000, 1'b1, 4'd8},  // R8 low-active, idle
        '{6'd0,  32'h0000_00FF, 6'd0,  32'h0000_0000, 1'b1, 4'd2},  // R2 pending write ignored
        '{6'd12, 32'h0002_0000, 6'd12, 32'h0002_0000, 1'b0, 4'd8},  // R8 high-active, idle
        '{6'd20, 32'h0000_DEAD, 6'd20, 32'h0000_0000, 1'b0, 4'd10}  // R10 unmapped
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
        addr = a; #1;
        chk(req, rdata, exp);
    endtask

    task automatic irq_chk(input string req, input logic exp);
        @(negedge clk);
        chk(req, {31'd0, irq_out}, {31'd0, exp});
    endtask

    initial begin
        #(4 * 50000);
        fails++; tests++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; pwr_on = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
        usb_evt = '0; dma_evt = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        rd_chk("R1", 6'd3,  32'hFFFF_FFFF);
        rd_chk("R1", 6'd7,  32'h0);
        rd_chk("R1", 6'd11, 32'h0);
        rd_chk("R1", 6'd12, 32'h0);
        rd_chk("R1", 6'd0,  32'h0);
        rd_chk("R1", 6'd4,  32'h0);
        irq_chk("R1", 1'b0);

        // R9 hold-off: low polarity and nothing pending, so an open gate drives 1
        @(negedge clk); pwr_on = 1'b1;
        repeat (HOLD + 1) @(posedge clk);
        irq_chk("R9", 1'b0);
        @(posedge clk);
        irq_chk("R9", 1'b1);
        // power off leaves gate open
        @(negedge clk); pwr_on = 1'b0;
        repeat (5) @(posedge clk);
        irq_chk("R9", 1'b1);
        // power on again closes gate at once
        @(negedge clk); pwr_on = 1'b1;
        @(posedge clk); @(posedge clk);
        irq_chk("R9", 1'b0);
        // power lost during hold keeps gate closed
        repeat (2) @(posedge clk);
        @(negedge clk); pwr_on = 1'b0;
        repeat (HOLD + 4) @(posedge clk);
        irq_chk("R9", 1'b0);
        @(negedge clk); pwr_on = 1'b1;
        repeat (HOLD + 1) @(posedge clk);
        irq_chk("R9", 1'b0);
        @(posedge clk);
        irq_chk("R9", 1'b1);

        // set-up for the walk
        wr(6'd12, 32'h0002_0000);
        wr(6'd3,  32'h0);
        @(posedge clk);

        for (int i = 0; i < 19; i++) begin
            wr(VECS[i].wa, VECS[i].wd);
            rd_chk($sformatf("R%0d", VECS[i].req), VECS[i].ra, VECS[i].rexp);
            @(posedge clk);
            irq_chk($sformatf("R%0d", VECS[i].req), VECS[i].irq);
        end

        // R11 line lags pending by one clock
        wr(6'd5, 32'h0000_0002);
        rd_chk("R11", 6'd0, 32'h0000_0200);
        chk("R11", {31'd0, irq_out}, 32'd0);
        @(posedge clk); #1;
        chk("R11", {31'd0, irq_out}, 32'd1);
        wr(6'd6, 32'h0000_0002);

        // R12 hardware events
        @(negedge clk); usb_evt = 32'h0004_0000;
        @(posedge clk); #1; usb_evt = '0;
        rd_chk("R12", 6'd4, 32'h0004_0000);
        rd_chk("R12", 6'd0, 32'h0000_0100);
        @(negedge clk); dma_evt = 32'h0000_0002;
        @(posedge clk); #1; dma_evt = '0;
        rd_chk("R12", 6'd8, 32'h0000_0002);
        rd_chk("R12", 6'd0, 32'h0100_0100);
        wr(6'd6,  32'hFFFF_FFFF);
        wr(6'd10, 32'hFFFF_FFFF);

        // R2 event and clear in the same cycle: clear wins
        @(negedge clk);
        usb_evt = 32'h0000_0004; wr_en = 1'b1; addr = 6'd6; wdata = 32'h0000_0004;
        @(posedge clk); #1;
        usb_evt = '0; wr_en = 1'b0;
        rd_chk("R2", 6'd4, 32'h0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule